// File: doc/BRIEF.md
# Gated Prescaled Timer Channel with Read-Clear Output Count

This block is one timer channel. It takes a base tick strobe from a clock divider outside the block. A stage-2 divider counts those base ticks. Each time the divider reaches a programmable 8-bit limit, it sends one pulse to a small stage-3 counter. Software polls the stage-3 counter through a read strobe. Every read returns the current count and clears it in the same operation.

Bit 0 of a shared control word turns the channel on and off. Only an off-to-on change of that bit restarts the channel. Turning the channel off freezes both counters, and the stage-3 count stays readable. A read that lands in the same cycle as a stage-3 increment never loses that increment.

The read data is combinational from the stage-3 register. All state changes happen at the rising clock edge that follows the strobes.

Top module: `gated_tick_timer`

## Requirements
- R1: After the synchronous reset the following hold. `rd_data` is 0. The channel is disabled. The limit is 0. Base ticks then leave `rd_data` at 0 until the channel is enabled.
- R2: A control write with bit 0 = 1 while the channel is disabled sets both the divider and the stage-3 count to zero at that edge.
- R3: A control write with bit 0 = 1 while the channel is already enabled changes neither the divider nor the stage-3 count.
- R4: A control write with bit 0 = 0 stops the channel. The stage-3 count keeps its value and a read still returns it.
- R5: While the channel is disabled, base ticks advance neither the divider nor the stage-3 count.
- R6: While enabled, the stage-3 count rises by one for every L base ticks. For a limit value of 1..255, L equals that value. For a limit value of 0, L is 256.
- R7: The count is visible on `rd_data` while `cnt_rd` is high. The edge that ends that cycle clears the count. A read does not disturb the divider phase.
- R8: If a read and a stage-3 increment fall in the same cycle, the read returns the old count and the count becomes 1.
- R9: The stage-3 count is 4 bits wide and wraps from 15 to 0. `rd_data[7:4]` is always 0.
- R10: A limit write takes effect from the next base tick. It does not reset the divider.
- R11: Only bit 0 of `ctrl_wdata` acts as the enable. Bits 7..1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Base tick strobe from the outside prescaler |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | Control word; bit 0 is the channel enable |
| tgt_we | input | 1 | Limit write strobe |
| tgt_wdata | input | 8 | Divider limit; 0 means 256 |
| cnt_rd | input | 1 | Read strobe for the stage-3 count |
| rd_data | output | 8 | Stage-3 count, zero-extended |

## Verification
Every strobe acts at the next rising edge. The divider, the enable and the stage-3 count all update at that edge. `rd_data` therefore shows the new count one cycle after the strobe that caused the change. During a read, `rd_data` shows the count as it stood before that read's clear. The bench drives inputs at the falling edge and advances its own model of enable, divider phase, limit and count by one step per cycle. It compares `rd_data` at the next falling edge. It also checks the read value in the read cycle itself, before the clear. Directed runs pin literal counts at the restart, hold, collision, wrap and limit-change points. A long seeded random run then mixes all of the strobes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Action applied to the stage-3 count in one cycle.
  typedef enum logic [1:0] {
    OP_HOLD      = 2'd0,
    OP_CLEAR     = 2'd1,
    OP_INC       = 2'd2,
    OP_CLEAR_INC = 2'd3
  } cnt_op_e;

  // Restart wins over everything. A read plus a hit gives clear-then-increment.
  function automatic cnt_op_e pick_op(input logic restart,
                                      input logic rd,
                                      input logic hit);
    if (restart)      return OP_CLEAR;
    if (rd && hit)    return OP_CLEAR_INC;
    if (rd)           return OP_CLEAR;
    if (hit)          return OP_INC;
    return OP_HOLD;
  endfunction

endpackage

// File: rtl/tmr_enable_ctl.sv
module tmr_enable_ctl #(
  parameter int CTRL_W = 8,
  parameter int EN_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  output logic              en_o,
  output logic              restart_o
);

  logic en_q;
  logic bit_in;

  assign bit_in    = wdata[EN_BIT];
  // Restart fires only on an off-to-on change of the enable bit.
  assign restart_o = wr && bit_in && !en_q;
  assign en_o      = en_q;

  always_ff @(posedge clk) begin
    if (rst)     en_q <= 1'b0;
    else if (wr) en_q <= bit_in;
  end

  p_en_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(en_q));
  p_restart_sets_en_r2: assert property (@(posedge clk) disable iff (rst)
    restart_o |=> en_q);

endmodule

// File: rtl/tmr_divider.sv
module tmr_divider #(
  parameter int TGT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             en,
  input  logic             tick,
  input  logic             tgt_we,
  input  logic [TGT_W-1:0] tgt_wdata,
  output logic             hit_o
);

  localparam int CW = TGT_W + 1;

  logic [TGT_W-1:0] div_q;
  logic [TGT_W-1:0] tgt_q;
  logic [CW-1:0]    nxt;
  logic             step_ok;

  // A limit of zero stands for the full range, 2**TGT_W.
  function automatic logic [CW-1:0] limit_of(input logic [TGT_W-1:0] t);
    if (t == '0) return CW'(1) << TGT_W;
    return {1'b0, t};
  endfunction

  function automatic logic [CW-1:0] bump(input logic [TGT_W-1:0] d);
    return {1'b0, d} + CW'(1);
  endfunction

  assign step_ok = tick && en && !restart;
  assign nxt     = bump(div_q);
  assign hit_o   = step_ok && (nxt == limit_of(tgt_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      tgt_q <= '0;
    end else begin
      if (tgt_we) tgt_q <= tgt_wdata;
      if (restart)      div_q <= '0;
      else if (hit_o)   div_q <= '0;
      else if (step_ok) div_q <= nxt[TGT_W-1:0];
    end
  end

  p_stall_r5: assert property (@(posedge clk) disable iff (rst)
    (!en && !restart) |=> $stable(div_q));
  p_restart_zero_r2: assert property (@(posedge clk) disable iff (rst)
    restart |=> (div_q == '0));
  p_hit_reload_r6: assert property (@(posedge clk) disable iff (rst)
    hit_o |=> (div_q == '0));
  p_tgt_keeps_phase_r10: assert property (@(posedge clk) disable iff (rst)
    (tgt_we && !restart && !tick) |=> $stable(div_q));

endmodule

// File: rtl/tmr_outcnt.sv
module tmr_outcnt
  import tmr_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int RD_W  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic            hit,
  input  logic            rd,
  output logic [RD_W-1:0] rd_data
);

  logic [CNT_W-1:0] cnt_q;
  cnt_op_e          op;

  assign op = pick_op(restart, rd, hit);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else begin
      case (op)
        OP_CLEAR:     cnt_q <= '0;
        OP_INC:       cnt_q <= cnt_q + CNT_W'(1);
        OP_CLEAR_INC: cnt_q <= CNT_W'(1);
        default:      cnt_q <= cnt_q;
      endcase
    end
  end

  generate
    if (RD_W > CNT_W) begin : g_pad
      assign rd_data = {{(RD_W-CNT_W){1'b0}}, cnt_q};
    end else begin : g_trunc
      assign rd_data = cnt_q[RD_W-1:0];
    end
  endgenerate

  p_collide_one_r8: assert property (@(posedge clk) disable iff (rst)
    (rd && hit && !restart) |=> (cnt_q == CNT_W'(1)));
  p_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (rd && !hit) |=> (cnt_q == '0));
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!rd && !hit && !restart) |=> $stable(cnt_q));
  p_inc_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (hit && !rd && !restart) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/gated_tick_timer.sv
module gated_tick_timer #(
  parameter int CTRL_W = 8,
  parameter int EN_BIT = 0,
  parameter int TGT_W  = 8,
  parameter int CNT_W  = 4,
  parameter int RD_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              tgt_we,
  input  logic [TGT_W-1:0]  tgt_wdata,
  input  logic              cnt_rd,
  output logic [RD_W-1:0]   rd_data
);

  logic en_w;
  logic restart_w;
  logic hit_w;

  tmr_enable_ctl #(.CTRL_W(CTRL_W), .EN_BIT(EN_BIT)) u_en (
    .clk(clk), .rst(rst), .wr(ctrl_we), .wdata(ctrl_wdata),
    .en_o(en_w), .restart_o(restart_w)
  );

  tmr_divider #(.TGT_W(TGT_W)) u_div (
    .clk(clk), .rst(rst), .restart(restart_w), .en(en_w), .tick(tick_i),
    .tgt_we(tgt_we), .tgt_wdata(tgt_wdata), .hit_o(hit_w)
  );

  tmr_outcnt #(.CNT_W(CNT_W), .RD_W(RD_W)) u_cnt (
    .clk(clk), .rst(rst), .restart(restart_w), .hit(hit_w), .rd(cnt_rd),
    .rd_data(rd_data)
  );

  p_no_hit_off_r5: assert property (@(posedge clk) disable iff (rst)
    !en_w |-> !hit_w);

endmodule

// File: tb/sim_gated_tick_timer.sv
module sim_gated_tick_timer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = 8'h00;
  logic       tgt_we = 1'b0;
  logic [7:0] tgt_wdata = 8'h00;
  logic       cnt_rd = 1'b0;
  logic [7:0] rd_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Bench model state.
  bit m_en = 1'b0;
  int m_div = 0;
  int m_tgt = 0;
  int m_cnt = 0;

  always #4 clk = ~clk;

  gated_tick_timer u0 (
    .clk(clk), .rst(rst), .tick_i(tick_i), .ctrl_we(ctrl_we),
    .ctrl_wdata(ctrl_wdata), .tgt_we(tgt_we), .tgt_wdata(tgt_wdata),
    .cnt_rd(cnt_rd), .rd_data(rd_data)
  );

  function automatic int period(input int t);
    return (t == 0) ? 256 : t;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, update the model, then compare at the next falling edge.
  task automatic step(input bit tk, input bit cw, input int cd,
                      input bit tw, input int td, input bit rd,
                      input string req);
    bit go;
    bit hit;
    if (rd) chk("R7 read value", int'(rd_data), m_cnt);
    tick_i = tk; ctrl_we = cw; ctrl_wdata = cd[7:0];
    tgt_we = tw; tgt_wdata = td[7:0]; cnt_rd = rd;
    go  = cw && cd[0] && !m_en;
    hit = 1'b0;
    if (go) m_div = 0;
    else if (tk && m_en) begin
      if (((m_div + 1) % 256 == period(m_tgt) % 256) && (m_div + 1 == period(m_tgt) || m_tgt == 0 && m_div == 255)) begin
        hit = 1'b1; m_div = 0;
      end else m_div = (m_div + 1) % 256;
    end
    if (go)            m_cnt = 0;
    else if (rd && hit) m_cnt = 1;
    else if (rd)       m_cnt = 0;
    else if (hit)      m_cnt = (m_cnt + 1) % 16;
    if (cw) m_en = cd[0];
    if (tw) m_tgt = td;
    @(negedge clk);
    tick_i = 0; ctrl_we = 0; tgt_we = 0; cnt_rd = 0;
    chk(req, int'(rd_data), m_cnt);
    chk("R9 upper bits", int'(rd_data[7:4]), 0);
  endtask

  task automatic ticks(input int n, input string req);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset count", int'(rd_data), 0);
    ticks(20, "R1 disabled after reset");
    chk("R1 still zero", int'(rd_data), 0);

    step(0, 0, 0, 1, 3, 0, "R10 limit write");
    step(0, 1, 1, 0, 0, 0, "R2 enable");
    ticks(4, "R6 limit 3");
    chk("R6 one hit after 4 ticks", int'(rd_data), 1);
    step(0, 1, 1, 0, 0, 0, "R3 rewrite enable");
    ticks(2, "R3 phase kept");
    chk("R3 divider not reset", int'(rd_data), 2);

    step(0, 1, 0, 0, 0, 0, "R4 disable");
    ticks(10, "R5 disabled ticks");
    chk("R4 count held", int'(rd_data), 2);
    step(0, 1, 8'hFE, 0, 0, 0, "R11 upper bits");
    ticks(5, "R11 still off");
    chk("R11 upper bits ignored", int'(rd_data), 2);
    step(0, 1, 1, 0, 0, 0, "R2 re-enable");
    chk("R2 count cleared", int'(rd_data), 0);

    ticks(2, "R2 phase 2");
    step(0, 1, 0, 0, 0, 0, "R2 off");
    step(0, 1, 1, 0, 0, 0, "R2 on");
    ticks(2, "R2 after restart");
    chk("R2 divider cleared", int'(rd_data), 0);
    ticks(1, "R2 third tick");
    chk("R2 hit after 3", int'(rd_data), 1);

    step(0, 0, 0, 0, 0, 1, "R7 read");
    chk("R7 cleared", int'(rd_data), 0);
    ticks(3, "R7 phase");
    ticks(2, "R8 prep");
    step(1, 0, 0, 0, 0, 1, "R8 collide");
    chk("R8 kept increment", int'(rd_data), 1);

    step(0, 0, 0, 1, 1, 0, "R9 limit 1");
    ticks(16, "R9 wrap");
    chk("R9 wrapped", int'(rd_data), 1);

    step(0, 0, 0, 1, 0, 1, "R6 limit 0");
    ticks(255, "R6 256 window");
    chk("R6 before 256", int'(rd_data), 0);
    ticks(1, "R6 at 256");
    chk("R6 limit zero is 256", int'(rd_data), 1);

    step(0, 0, 0, 1, 10, 1, "R10 limit 10");
    ticks(4, "R10 phase");
    step(0, 0, 0, 1, 6, 0, "R10 change");
    ticks(1, "R10 tick 5");
    chk("R10 no early hit", int'(rd_data), 0);
    ticks(1, "R10 tick 6");
    chk("R10 new limit used", int'(rd_data), 1);

    for (int i = 0; i < 4000; i++) begin
      bit tk = ($urandom % 2) == 0;
      bit cw = ($urandom % 40) == 0;
      int cd = $urandom % 256;
      bit tw = ($urandom % 60) == 0;
      int td = $urandom % 8;
      bit rd = ($urandom % 5) == 0;
      if (($urandom % 4) != 0) cd = cd | 1;
      step(tk, cw, cd, tw, td, rd, "R6 random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule